// File: doc/BRIEF.md
# Segment Address Translation and Protection Unit

This block maps a 32-bit logical address onto a 36-bit physical address through a bank of sixteen programmable segment descriptors, and it decides whether the requested access is allowed. Each descriptor defines a window whose size is a power of two. Only the logical address bits above the window size are compared against the descriptor's logical base. When a window matches, those upper bits are replaced by the descriptor's 24-bit replacement base, and the bits inside the window pass through unchanged. This lets a 32-bit requester reach memory above 4 GB.

Every descriptor also carries separate read, write and execute grants for the supervisor and user privilege levels. A lookup presents an address, an access kind and a privilege level. One cycle later the block reports whether a segment matched, whether the access violates that segment's grants, and the translated address. Software programs the descriptors through a plain register write port. The read port is combinational. Each descriptor occupies two 32-bit words at an 8-byte stride.

Top module: `seg_xlate_unit`

## Requirements
- R1: After reset every descriptor word reads as zero, every segment is disabled, and the response outputs are zero.
- R2: Descriptor N has its match word at byte offset N*8 and its translation word at N*8+4. The match word holds the size code in bits 4:0 and the logical base in bits 31:12, and bits 11:5 read as zero. The translation word holds the grants in bits 5:0 and the replacement base in bits 31:8, and bits 7:6 read as zero. A write whose offset bits 1:0 are not zero is ignored.
- R3: A size code below 11 disables its segment, so that segment never matches.
- R4: A size code c (11 to 31) defines a window of 2^(c+1) bytes. Only logical address bits c+1 and above are compared with the logical base, and base bits below c+1 are ignored.
- R5: On a permitted hit, bits 35:c+1 of the physical address come from {replacement base, 12'b0}, and bits c:0 come from the logical address.
- R6: When several enabled segments match, the one with the highest index supplies the translation and the grants.
- R7: Grant bits are 5=supervisor read, 4=supervisor write, 3=supervisor execute, 2=user read, 1=user write, 0=user execute. Access kind 0 is read, 1 is write, 2 is execute, and 3 is never granted. Privilege 1 is supervisor and 0 is user. A hit without the needed grant sets the fault output and forces the physical address to zero.
- R8: A lookup that matches no segment returns hit=0, fault=0 and a physical address of zero.
- R9: The response for a lookup appears on the cycle after it is presented. A cycle with no lookup yields valid, hit and fault all low on the next cycle. Lookups may be presented back to back.
- R10: A descriptor write affects lookups presented from the following cycle on. A lookup in the same cycle as the write sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Descriptor word write strobe |
| cfg_addr | input | 7 | Byte offset of the descriptor word |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Combinational read data at cfg_addr |
| lk_valid | input | 1 | Lookup request present |
| lk_addr | input | 32 | Logical address |
| lk_acc | input | 2 | Access kind (0 read, 1 write, 2 execute) |
| lk_sup | input | 1 | 1 for supervisor, 0 for user |
| rsp_valid | output | 1 | Response present, one cycle after a lookup |
| rsp_hit | output | 1 | An enabled segment matched |
| rsp_fault | output | 1 | Matched, but the access is not granted |
| rsp_paddr | output | 36 | Translated physical address |

## Verification
The hardest conditions to reach are the window edges at the largest sizes and the overlap between segments. At the 2 GB and 4 GB sizes, the address one past the window wraps around the 32-bit space. A priority error is visible only when two enabled windows really overlap. The bench therefore sweeps all 32 size codes and probes the last byte inside each window, the first byte outside it and the byte just below its base, once with an aligned base and once with a base that has stray low bits. It then stacks all sixteen segments on one region and disables them from the top down, so that each index in turn has to win. A separate cycle places a descriptor write alongside a lookup to expose which contents the lookup sees.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

    localparam int unsigned WORD_W     = 32;
    localparam int unsigned CODE_W     = 5;
    localparam int unsigned PERM_W     = 6;
    localparam int unsigned PAGE_SHIFT = 12;
    localparam int unsigned LBASE_W    = 20;
    localparam int unsigned RBASE_W    = 24;
    localparam int unsigned LADDR_W    = LBASE_W + PAGE_SHIFT;
    localparam int unsigned PADDR_W    = RBASE_W + PAGE_SHIFT;

    // access kind encoding
    localparam logic [1:0] ACC_READ  = 2'd0;
    localparam logic [1:0] ACC_WRITE = 2'd1;
    localparam logic [1:0] ACC_EXEC  = 2'd2;

    typedef struct packed {
        logic [LBASE_W-1:0] lbase;
        logic [CODE_W-1:0]  code;
    } match_word_t;

    typedef struct packed {
        logic [RBASE_W-1:0] rbase;
        logic [PERM_W-1:0]  perm;
    } xlat_word_t;

    typedef struct packed {
        match_word_t m;
        xlat_word_t  x;
    } seg_desc_t;

    typedef struct packed {
        logic               valid;
        logic               hit;
        logic               fault;
        logic [PADDR_W-1:0] paddr;
    } seg_rsp_t;

    // grant lookup: supervisor grants sit three bits above the user ones
    function automatic logic grant_ok(input logic [PERM_W-1:0] perm,
                                      input logic [1:0] acc,
                                      input logic sup);
        logic [2:0] trio;
        logic       ok;
        trio = sup ? perm[5:3] : perm[2:0];
        case (acc)
            ACC_READ:  ok = trio[2];
            ACC_WRITE: ok = trio[1];
            ACC_EXEC:  ok = trio[0];
            default:   ok = 1'b0;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/seg_desc_bank.sv
module seg_desc_bank
    import seg_xlate_pkg::*;
#(
    parameter int unsigned NUM_SEG = 16,
    localparam int unsigned SEL_W  = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1,
    localparam int unsigned CFG_AW = SEL_W + 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [CFG_AW-1:0]         addr,
    input  logic [WORD_W-1:0]         wdata,
    output logic [WORD_W-1:0]         rdata,
    output seg_desc_t [NUM_SEG-1:0]   tab
);

    seg_desc_t [NUM_SEG-1:0] tab_d, tab_q;

    logic [SEL_W-1:0] seg_idx;
    logic             seg_in_range;
    logic             aligned;

    assign seg_idx      = addr[CFG_AW-1:3];
    assign seg_in_range = (int'(seg_idx) < int'(NUM_SEG));
    assign aligned      = (addr[1:0] == 2'b00);

    always_comb begin
        tab_d = tab_q;
        if (we && aligned && seg_in_range) begin
            if (addr[2]) begin
                tab_d[seg_idx].x.rbase = wdata[WORD_W-1:8];
                tab_d[seg_idx].x.perm  = wdata[PERM_W-1:0];
            end else begin
                tab_d[seg_idx].m.lbase = wdata[WORD_W-1:PAGE_SHIFT];
                tab_d[seg_idx].m.code  = wdata[CODE_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tab_q <= '0;
        else        tab_q <= tab_d;
    end

    always_comb begin
        rdata = '0;
        if (seg_in_range) begin
            if (addr[2])
                rdata = {tab_q[seg_idx].x.rbase, 2'b00, tab_q[seg_idx].x.perm};
            else
                rdata = {tab_q[seg_idx].m.lbase, 7'b0000000, tab_q[seg_idx].m.code};
        end
    end

    assign tab = tab_q;

    // R2: reserved fields of either word never read back as one
    p_resv_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (addr[2] ? (rdata[7:6] == 2'b00) : (rdata[11:5] == 7'd0)));

    // R10: a write at an aligned offset is visible on the next cycle
    p_write_lands_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (we && aligned && seg_in_range && !addr[2])
        |=> (tab_q[$past(seg_idx)].m.code == $past(wdata[CODE_W-1:0])));

endmodule

// File: rtl/seg_match_lane.sv
module seg_match_lane
    import seg_xlate_pkg::*;
#(
    parameter int unsigned MIN_CODE = 11
) (
    input  seg_desc_t           desc,
    input  logic [LADDR_W-1:0]  laddr,
    output logic                hit,
    output logic [PADDR_W-1:0]  paddr
);

    logic                enabled;
    logic [5:0]          nbits;
    logic [LADDR_W:0]    low_l;
    logic [LADDR_W-1:0]  keep_l;
    logic [PADDR_W-1:0]  low_p;
    logic [LADDR_W-1:0]  base_l;
    logic [PADDR_W-1:0]  base_p;

    always_comb begin
        enabled = (desc.m.code >= CODE_W'(MIN_CODE));
        nbits   = {1'b0, desc.m.code} + 6'd1;
        low_l   = ({{LADDR_W{1'b0}}, 1'b1} << nbits) - {{LADDR_W{1'b0}}, 1'b1};
        keep_l  = ~low_l[LADDR_W-1:0];
        low_p   = {{(PADDR_W-LADDR_W-1){1'b0}}, low_l};
        base_l  = {desc.m.lbase, {PAGE_SHIFT{1'b0}}};
        base_p  = {desc.x.rbase, {PAGE_SHIFT{1'b0}}};
        hit     = enabled && (((laddr ^ base_l) & keep_l) == '0);
        paddr   = (base_p & ~low_p) | ({{(PADDR_W-LADDR_W){1'b0}}, laddr} & low_p);
    end

endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
    import seg_xlate_pkg::*;
#(
    parameter int unsigned NUM_SEG  = 16,
    parameter int unsigned MIN_CODE = 11,
    localparam int unsigned SEL_W   = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1,
    localparam int unsigned CFG_AW  = SEL_W + 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [CFG_AW-1:0]    cfg_addr,
    input  logic [WORD_W-1:0]    cfg_wdata,
    output logic [WORD_W-1:0]    cfg_rdata,
    input  logic                 lk_valid,
    input  logic [LADDR_W-1:0]   lk_addr,
    input  logic [1:0]           lk_acc,
    input  logic                 lk_sup,
    output logic                 rsp_valid,
    output logic                 rsp_hit,
    output logic                 rsp_fault,
    output logic [PADDR_W-1:0]   rsp_paddr
);

    seg_desc_t [NUM_SEG-1:0]  tab;
    logic [NUM_SEG-1:0]       lane_hit;
    logic [PADDR_W-1:0]       lane_paddr [NUM_SEG];

    seg_desc_bank #(.NUM_SEG(NUM_SEG)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .addr  (cfg_addr),
        .wdata (cfg_wdata),
        .rdata (cfg_rdata),
        .tab   (tab)
    );

    for (genvar g = 0; g < NUM_SEG; g++) begin : g_lane
        seg_match_lane #(.MIN_CODE(MIN_CODE)) u_lane (
            .desc  (tab[g]),
            .laddr (lk_addr),
            .hit   (lane_hit[g]),
            .paddr (lane_paddr[g])
        );

        // R3: a descriptor with a small size code never produces a match
        p_small_code_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (tab[g].m.code < CODE_W'(MIN_CODE)) |-> !lane_hit[g]);
    end

    seg_rsp_t             rsp_d, rsp_q;
    logic                 any_hit;
    logic                 allowed;
    logic [PADDR_W-1:0]   sel_paddr;
    logic [PERM_W-1:0]    sel_perm;

    always_comb begin
        any_hit   = 1'b0;
        sel_paddr = '0;
        sel_perm  = '0;
        // later (higher) indices overwrite earlier ones: highest match wins
        for (int i = 0; i < int'(NUM_SEG); i++) begin
            if (lane_hit[i]) begin
                any_hit   = 1'b1;
                sel_paddr = lane_paddr[i];
                sel_perm  = tab[i].x.perm;
            end
        end
        allowed = grant_ok(sel_perm, lk_acc, lk_sup);

        rsp_d = '0;
        if (lk_valid) begin
            rsp_d.valid = 1'b1;
            rsp_d.hit   = any_hit;
            rsp_d.fault = any_hit && !allowed;
            rsp_d.paddr = (any_hit && allowed) ? sel_paddr : '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_hit   = rsp_q.hit;
    assign rsp_fault = rsp_q.fault;
    assign rsp_paddr = rsp_q.paddr;

    // R9: a lookup is answered on the following cycle
    p_answer_next_r9: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rsp_valid);

    // R9: an idle cycle produces a quiet response
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> (!rsp_valid && !rsp_hit && !rsp_fault));

    // R7: a fault is only raised against a matched segment, and it zeroes the address
    p_fault_on_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (rsp_hit && rsp_paddr == '0));

    // R8: a miss carries a zero address
    p_miss_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit) |-> (rsp_paddr == '0 && !rsp_fault));

    // R5: the bottom page offset always passes through on a granted hit
    p_offset_kept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_hit && !rsp_fault)
        |-> (rsp_paddr[PAGE_SHIFT-1:0] == $past(lk_addr[PAGE_SHIFT-1:0])));

endmodule

// File: tb/seg_xlate_unit_test.sv
module seg_xlate_unit_test;

    localparam int NSEG = 16;
    localparam int AW   = 7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [AW-1:0] cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_addr = '0;
    logic [1:0]  lk_acc = '0;
    logic        lk_sup = 1'b0;
    logic        rsp_valid, rsp_hit, rsp_fault;
    logic [35:0] rsp_paddr;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    logic [31:0] sh_m [NSEG];
    logic [31:0] sh_x [NSEG];

    always #2 clk = ~clk;   // 250 MHz

    seg_xlate_unit uut (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_acc(lk_acc), .lk_sup(lk_sup),
        .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // expected {hit, fault, paddr} from the requirements
    function automatic logic [37:0] model(input logic [31:0] a, input logic [1:0] acc, input logic sup);
        logic        h = 1'b0;
        logic [5:0]  pm = '0;
        logic [63:0] p = '0;
        logic [63:0] a64, span, lb, rb;
        int          c, bitpos;
        logic        ok;
        a64 = {32'd0, a};
        for (int i = 0; i < NSEG; i++) begin
            c = int'(sh_m[i][4:0]);
            if (c >= 11) begin
                span = 64'd1 << (c + 1);
                lb   = {32'd0, sh_m[i][31:12], 12'd0};
                if ((a64 / span) == (lb / span)) begin
                    h  = 1'b1;
                    pm = sh_x[i][5:0];
                    rb = {28'd0, sh_x[i][31:8], 12'd0};
                    p  = (rb / span) * span + (a64 % span);
                end
            end
        end
        bitpos = (sup ? 5 : 2) - int'(acc);
        ok = (acc != 2'd3) && pm[bitpos];
        return {h, h && !ok, (h && ok) ? p[35:0] : 36'd0};
    endfunction

    task automatic wr(input int seg, input bit xword, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = AW'(seg * 8 + (xword ? 4 : 0)); cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (xword) sh_x[seg] = d & 32'hFFFF_FF3F;
        else       sh_m[seg] = d & 32'hFFFF_F01F;
    endtask

    task automatic rd_chk(input int seg, input bit xword, input string req);
        @(negedge clk);
        cfg_addr = AW'(seg * 8 + (xword ? 4 : 0));
        #1;
        chk(req, {32'd0, cfg_rdata}, {32'd0, xword ? sh_x[seg] : sh_m[seg]});
    endtask

    task automatic lk(input logic [31:0] a, input logic [1:0] acc, input logic sup, input string req);
        logic [37:0] e;
        @(negedge clk);
        lk_valid = 1'b1; lk_addr = a; lk_acc = acc; lk_sup = sup;
        e = model(a, acc, sup);
        @(negedge clk);
        lk_valid = 1'b0;
        chk(req, {25'd0, rsp_valid, rsp_hit, rsp_fault, rsp_paddr}, {25'd0, 1'b1, e});
    endtask

    task automatic clear_all();
        for (int s = 0; s < NSEG; s++) begin
            wr(s, 1'b0, 32'd0);
            wr(s, 1'b1, 32'd0);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_up();
    end

    initial begin
        logic [31:0] bases [2];
        logic [31:0] span32;
        for (int s = 0; s < NSEG; s++) begin sh_m[s] = '0; sh_x[s] = '0; end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        @(negedge clk);
        chk("R1 rsp after reset", {61'd0, rsp_valid, rsp_hit, rsp_fault}, 64'd0);
        chk("R1 paddr after reset", {28'd0, rsp_paddr}, 64'd0);
        for (int s = 0; s < NSEG; s++) begin
            rd_chk(s, 1'b0, "R1 match word reset");
            rd_chk(s, 1'b1, "R1 xlat word reset");
        end
        lk(32'h8000_0000, 2'd0, 1'b1, "R1 lookup after reset misses");

        // R2: layout and reserved bits
        for (int s = 0; s < NSEG; s++) begin
            wr(s, 1'b0, 32'hA5C3_1F00 ^ (32'(s) * 32'h1357_9BDF));
            wr(s, 1'b1, 32'h5A3C_E1FF ^ (32'(s) * 32'h0246_8ACE));
        end
        for (int s = 0; s < NSEG; s++) begin
            rd_chk(s, 1'b0, "R2 match word readback");
            rd_chk(s, 1'b1, "R2 xlat word readback");
        end
        // R2: misaligned offset write ignored
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = AW'(3 * 8 + 1); cfg_wdata = 32'hFFFF_FFFF;
        @(negedge clk);
        cfg_we = 1'b0;
        rd_chk(3, 1'b0, "R2 misaligned write ignored");
        clear_all();

        // R3 R4 R5 R8: size sweep, aligned and unaligned base
        bases[0] = 32'h8000_0000;
        bases[1] = 32'h8123_4000;
        for (int b = 0; b < 2; b++) begin
            for (int c = 0; c < 32; c++) begin
                wr(0, 1'b0, bases[b] | 32'(c));
                wr(0, 1'b1, 32'hAB_C3D0_3F);
                span32 = (c >= 31) ? 32'hFFFF_FFFF : ((32'd1 << (c + 1)) - 32'd1);
                lk((bases[b] & ~span32) | span32, 2'd0, 1'b1, "R4 last byte in window");
                lk(((bases[b] & ~span32) | span32) + 32'd1, 2'd1, 1'b0, "R4 first byte past window");
                lk((bases[b] & ~span32) - 32'd1, 2'd2, 1'b1, "R8 byte below window");
                lk((bases[b] & ~span32) | (32'h3C96_A5E7 & span32), 2'd0, 1'b0, "R5 offset pass-through");
                if (c < 11) lk(bases[b], 2'd0, 1'b1, "R3 small code disabled");
            end
        end
        clear_all();

        // R5: 1 GB window onto memory above 4 GB
        wr(1, 1'b0, 32'h8000_001D);
        wr(1, 1'b1, 32'h1C00_003F);
        @(negedge clk);
        lk_valid = 1'b1; lk_addr = 32'h8765_4321; lk_acc = 2'd1; lk_sup = 1'b0;
        @(negedge clk);
        lk_valid = 1'b0;
        chk("R5 high physical address", {24'd0, rsp_hit, rsp_fault, 2'b00, rsp_paddr}, {24'd0, 2'b10, 2'b00, 36'h1_C765_4321});
        clear_all();

        // R7: grant sweep
        wr(2, 1'b0, 32'h0001_000B);
        for (int pm = 0; pm < 64; pm++) begin
            wr(2, 1'b1, 32'h0012_3400 | 32'(pm));
            for (int acc = 0; acc < 4; acc++) begin
                lk(32'h0001_0ABC, 2'(acc), 1'b1, "R7 supervisor grant");
                lk(32'h0001_0ABC, 2'(acc), 1'b0, "R7 user grant");
            end
        end
        wr(2, 1'b1, 32'h0000_0036);
        lk(32'h0001_0004, 2'd2, 1'b1, "R7 0x36 denies execute");
        clear_all();

        // R6: stacked segments, disabled from the top down
        for (int s = 0; s < NSEG; s++) begin
            wr(s, 1'b0, 32'h0C00_0013);
            wr(s, 1'b1, (32'(s + 1) << 16) | 32'h3F);
        end
        for (int s = NSEG - 1; s >= 0; s--) begin
            lk(32'h0C0F_1234, 2'd0, 1'b1, "R6 highest index wins");
            wr(s, 1'b0, 32'h0C00_0000);
        end
        lk(32'h0C0F_1234, 2'd0, 1'b1, "R8 all disabled miss");

        // R9: idle cycle and back-to-back stream
        @(negedge clk);
        lk_valid = 1'b0;
        @(negedge clk);
        chk("R9 idle response", {61'd0, rsp_valid, rsp_hit, rsp_fault}, 64'd0);
        wr(5, 1'b0, 32'h4000_0015);
        wr(5, 1'b1, 32'h0F_0000_3F);
        begin
            logic [37:0] prev;
            @(negedge clk);
            for (int j = 0; j < 24; j++) begin
                lk_valid = 1'b1;
                lk_addr  = 32'h3FFC_0000 + 32'(j) * 32'h0000_4321;
                lk_acc   = 2'(j % 3);
                lk_sup   = 1'(j % 2);
                if (j > 0)
                    chk("R9 back-to-back", {25'd0, rsp_valid, rsp_hit, rsp_fault, rsp_paddr}, {25'd0, 1'b1, prev});
                prev = model(lk_addr, lk_acc, lk_sup);
                @(negedge clk);
            end
            lk_valid = 1'b0;
            chk("R9 back-to-back last", {25'd0, rsp_valid, rsp_hit, rsp_fault, rsp_paddr}, {25'd0, 1'b1, prev});
        end

        // R10: lookup alongside a write sees the old contents
        wr(5, 1'b0, 32'h0000_0000);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = AW'(7 * 8); cfg_wdata = 32'h9000_000B;
        lk_valid = 1'b1; lk_addr = 32'h9000_0010; lk_acc = 2'd0; lk_sup = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0; lk_valid = 1'b0;
        chk("R10 same-cycle lookup sees old", {62'd0, rsp_valid, rsp_hit}, {62'd0, 2'b10});
        sh_m[7] = 32'h9000_000B;
        wr(7, 1'b1, 32'h0000_0024);
        lk(32'h9000_0010, 2'd0, 1'b1, "R10 next-cycle lookup sees new");

        finish_up();
    end

endmodule